// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block samples a parallel image sensor bus made of a pixel clock, a vertical sync, a horizontal sync and up to 12 data bits. It works with plain 8-bit, 10-bit and 12-bit sensors that carry no embedded sync codes. The block runs entirely in the system clock domain. It oversamples the sensor pixel clock and takes one sample on the chosen edge of that clock. Pixels that fall inside an active frame and an active line are packed into 32-bit words. The words leave through a valid/ready stream meant for a downstream FIFO write port.

Configuration is held on plain input pins: enable, deferred-disable mode, start-of-frame arming, the two sync polarities, the sampling edge, lane swap and data width. Four one-cycle event pulses mark frame start, frame end, line start and line end.

The output stream uses a single holding register. While `out_valid` is high and `out_ready` is low, `out_data` stays stable. A packed word that completes while the holding register still holds an unaccepted word is discarded, and the held word is kept. The downstream port must therefore accept each word before the next one completes.

Top module: `cam_capture`

## Requirements
- R1: `vs_pol` and `hs_pol` invert their sync inputs before any qualification. A value of 0 means active high and 1 means active low.
- R2: `pclk_pol` = 0 samples the bus on rising edges of `cam_pclk`, and 1 samples it on falling edges. Values present at the other edge are never captured.
- R3: With `sof_mode` = 0, capture starts at any sample where vertical sync is active and the block is enabled, including in the middle of a frame. With `sof_mode` = 1, capture starts only at a sample where vertical sync changes from inactive to active.
- R4: When `en` is low and `frame_trig` is 1, a frame in progress finishes normally, with its words and its frame-end pulse. No new frame starts after that.
- R5: When `en` is low and `frame_trig` is 0, capture stops at once. The frame is dropped with no further event pulse, and any partly packed word is discarded.
- R6: `width_mode` 2'b00 selects 8-bit pixels, four per word. With `swap` = 0, the first pixel goes in bits [7:0] and later pixels fill upward.
- R7: `width_mode` 2'b01 selects 10-bit pixels and 2'b10 or 2'b11 selects 12-bit pixels. Two pixels go in each word, each masked to its width and zero-extended to 16 bits. With `swap` = 0, the first pixel is in bits [15:0].
- R8: `swap` = 1 reverses the lane order, so the first pixel of a word lands in the most significant lane.
- R9: At line end, a partly filled word is emitted with its unused lanes at zero.
- R10: `evt_fs`, `evt_fe`, `evt_ls` and `evt_le` each pulse for one cycle. A line that is still open when the frame ends also gets a line-end pulse.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. A word that completes during the stall is dropped.
- R12: Pulsing `core_rst`, which is allowed only while `en` is low, clears the frame and line state, the packer and the holding register.
- R13: After `rst_n` is asserted, `out_valid` and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_rst | input | 1 | Synchronous clear of the capture state, applied only while disabled |
| en | input | 1 | Capture enable |
| frame_trig | input | 1 | 1: disabling waits for the end of the frame |
| sof_mode | input | 1 | 1: arm on the vertical sync rising transition |
| vs_pol | input | 1 | Vertical sync polarity (1 = active low) |
| hs_pol | input | 1 | Horizontal sync polarity (1 = active low) |
| pclk_pol | input | 1 | Sampling edge (0 rising, 1 falling) |
| swap | input | 1 | Reverse lane order in packed words |
| width_mode | input | 2 | 00 8-bit, 01 10-bit, 1x 12-bit |
| cam_pclk | input | 1 | Sensor pixel clock, oversampled |
| cam_vs | input | 1 | Sensor vertical sync |
| cam_hs | input | 1 | Sensor horizontal sync |
| cam_d | input | 12 | Sensor pixel data, LSB aligned |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed pixel word |
| evt_fs | output | 1 | Frame start pulse |
| evt_fe | output | 1 | Frame end pulse |
| evt_ls | output | 1 | Line start pulse |
| evt_le | output | 1 | Line end pulse |

## Verification
Single-line frames are run across all three widths, both lane orders and line lengths of 1, 3, 4 and 6 pixels. Together they separate full words from flushed partial words, lane placement from masking, and the 10-bit mask from the 12-bit mask. The bench drives junk data at the non-sampling pixel-clock edge, so a design that samples the wrong edge produces wrong words. Paired runs separate level arming from edge arming and deferred disable from immediate disable. A stalled sink and a core reset in the middle of a frame show that only the expected words survive.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  typedef enum logic [1:0] {
    WM_8   = 2'b00,
    WM_10  = 2'b01,
    WM_12  = 2'b10,
    WM_12B = 2'b11
  } width_mode_e;

  localparam logic [15:0] MASK_8  = 16'h00FF;
  localparam logic [15:0] MASK_10 = 16'h03FF;
  localparam logic [15:0] MASK_12 = 16'h0FFF;
endpackage

// File: rtl/cam_sync_front.sv
module cam_sync_front #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_pol,
  input  logic             vs_pol,
  input  logic             hs_pol,
  input  logic             cam_pclk,
  input  logic             cam_vs,
  input  logic             cam_hs,
  input  logic [PIX_W-1:0] cam_d,
  output logic             tick,
  output logic             vs_s,
  output logic             hs_s,
  output logic [PIX_W-1:0] d_s
);
  logic pclk_q;
  logic edge_hit;

  // Edge detect on the oversampled pixel clock; polarity picks the edge.
  assign edge_hit = pclk_pol ? (pclk_q & ~cam_pclk) : (~pclk_q & cam_pclk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      tick   <= 1'b0;
      vs_s   <= 1'b0;
      hs_s   <= 1'b0;
      d_s    <= '0;
    end else begin
      pclk_q <= cam_pclk;
      tick   <= edge_hit;
      if (edge_hit) begin
        vs_s <= cam_vs ^ vs_pol;
        hs_s <= cam_hs ^ hs_pol;
        d_s  <= cam_d;
      end
    end
  end
endmodule

// File: rtl/cam_frame_ctrl.sv
module cam_frame_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst,
  input  logic en,
  input  logic frame_trig,
  input  logic sof_mode,
  input  logic tick,
  input  logic vs_s,
  input  logic hs_s,
  output logic abort,
  output logic pix_ok,
  output logic line_done,
  output logic evt_fs,
  output logic evt_fe,
  output logic evt_ls,
  output logic evt_le
);
  logic in_frame, in_line, vs_prev;
  logic start, act, hs_act;

  assign abort     = core_rst | (~en & ~frame_trig);
  assign start     = ~in_frame & en & vs_s & (~sof_mode | ~vs_prev);
  assign act       = vs_s & (in_frame | start);
  assign hs_act    = act & hs_s;
  assign pix_ok    = tick & ~abort & hs_act;
  assign line_done = tick & ~abort & in_line & ~hs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      in_line  <= 1'b0;
      vs_prev  <= 1'b0;
      evt_fs   <= 1'b0;
      evt_fe   <= 1'b0;
      evt_ls   <= 1'b0;
      evt_le   <= 1'b0;
    end else begin
      evt_fs <= 1'b0;
      evt_fe <= 1'b0;
      evt_ls <= 1'b0;
      evt_le <= 1'b0;
      if (tick) vs_prev <= vs_s;
      if (abort) begin
        in_frame <= 1'b0;
        in_line  <= 1'b0;
      end else if (tick) begin
        in_frame <= act;
        in_line  <= hs_act;
        evt_fs   <= start;
        evt_fe   <= in_frame & ~vs_s;
        evt_ls   <= hs_act & ~in_line;
        evt_le   <= in_line & ~hs_act;
      end
    end
  end
endmodule

// File: rtl/cam_pixel_packer.sv
module cam_pixel_packer
  import cam_cap_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pix_ok,
  input  logic              line_done,
  input  logic [PIX_W-1:0]  pix,
  input  width_mode_e       wmode,
  input  logic              swap,
  output logic              w_vld,
  output logic [WORD_W-1:0] w_data
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int CW  = $clog2(N8);

  logic [CW-1:0]     cnt, last, lane;
  logic              narrow;
  logic [15:0]       pv;
  logic [WORD_W-1:0] acc, place8, place16, merged;

  assign narrow = (wmode == WM_8);
  assign last   = narrow ? CW'(N8 - 1) : CW'(N16 - 1);
  assign lane   = swap ? (last - cnt) : cnt;

  always_comb begin
    unique case (wmode)
      WM_8:    pv = 16'(pix) & MASK_8;
      WM_10:   pv = 16'(pix) & MASK_10;
      default: pv = 16'(pix) & MASK_12;
    endcase
  end

  for (genvar g = 0; g < N8; g++) begin : g_lane8
    assign place8[g*8 +: 8] = (narrow && lane == CW'(g)) ? pv[7:0] : 8'h00;
  end
  for (genvar g = 0; g < N16; g++) begin : g_lane16
    assign place16[g*16 +: 16] = (!narrow && lane == CW'(g)) ? pv : 16'h0000;
  end

  assign merged = acc | place8 | place16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      w_vld  <= 1'b0;
      w_data <= '0;
    end else begin
      w_vld <= 1'b0;
      if (clr) begin
        acc <= '0;
        cnt <= '0;
      end else if (pix_ok) begin
        if (cnt == last) begin
          w_vld  <= 1'b1;
          w_data <= merged;
          acc    <= '0;
          cnt    <= '0;
        end else begin
          acc <= merged;
          cnt <= cnt + CW'(1);
        end
      end else if (line_done && cnt != '0) begin
        w_vld  <= 1'b1;
        w_data <= acc;
        acc    <= '0;
        cnt    <= '0;
      end
    end
  end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_cap_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              en,
  input  logic              frame_trig,
  input  logic              sof_mode,
  input  logic              vs_pol,
  input  logic              hs_pol,
  input  logic              pclk_pol,
  input  logic              swap,
  input  logic [1:0]        width_mode,
  input  logic              cam_pclk,
  input  logic              cam_vs,
  input  logic              cam_hs,
  input  logic [PIX_W-1:0]  cam_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              evt_fs,
  output logic              evt_fe,
  output logic              evt_ls,
  output logic              evt_le
);
  logic              tick, vs_s, hs_s;
  logic [PIX_W-1:0]  d_s;
  logic              abort, pix_ok, line_done;
  logic              w_vld;
  logic [WORD_W-1:0] w_data;

  cam_sync_front #(.PIX_W(PIX_W)) u_front (
    .clk(clk), .rst_n(rst_n), .pclk_pol(pclk_pol), .vs_pol(vs_pol),
    .hs_pol(hs_pol), .cam_pclk(cam_pclk), .cam_vs(cam_vs), .cam_hs(cam_hs),
    .cam_d(cam_d), .tick(tick), .vs_s(vs_s), .hs_s(hs_s), .d_s(d_s)
  );

  cam_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .en(en),
    .frame_trig(frame_trig), .sof_mode(sof_mode), .tick(tick), .vs_s(vs_s),
    .hs_s(hs_s), .abort(abort), .pix_ok(pix_ok), .line_done(line_done),
    .evt_fs(evt_fs), .evt_fe(evt_fe), .evt_ls(evt_ls), .evt_le(evt_le)
  );

  cam_pixel_packer #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(abort), .pix_ok(pix_ok),
    .line_done(line_done), .pix(d_s), .wmode(width_mode_e'(width_mode)),
    .swap(swap), .w_vld(w_vld), .w_data(w_data)
  );

  // Single holding register: a word arriving while stalled is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (core_rst) begin
      out_valid <= 1'b0;
    end else if (w_vld && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= w_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst,
  input logic              en,
  input logic              frame_trig,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              evt_fs,
  input logic              evt_fe,
  input logic              evt_ls,
  input logic              evt_le
);
  AST_FRAME_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_fs, evt_fe})); // R10
  AST_LINE_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_ls, evt_le})); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !core_rst) |=> (out_valid && $stable(out_data))); // R11
  AST_CORE_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !en); // R12
  AST_CORE_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !out_valid); // R12
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !frame_trig) |=> !(evt_fs || evt_fe || evt_ls || evt_le)); // R5
endmodule

bind cam_capture cam_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .en(en),
  .frame_trig(frame_trig), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .evt_fs(evt_fs), .evt_fe(evt_fe), .evt_ls(evt_ls),
  .evt_le(evt_le)
);

// File: tb/cam_capture_bench.sv
module cam_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_rst = 1'b0, en = 1'b0, frame_trig = 1'b0, sof_mode = 1'b0;
  logic        vs_pol = 1'b0, hs_pol = 1'b0, pclk_pol = 1'b0, swap = 1'b0;
  logic [1:0]  width_mode = 2'b00;
  logic        cam_pclk = 1'b0, cam_vs = 1'b0, cam_hs = 1'b0;
  logic [11:0] cam_d = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic        evt_fs, evt_fe, evt_ls, evt_le;

  int errors = 0, checks = 0;
  int n_got = 0, n_fs = 0, n_fe = 0, n_ls = 0, n_le = 0;
  logic [31:0] got [0:63];

  always #4 clk = ~clk;

  cam_capture u_cam_capture (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .en(en),
    .frame_trig(frame_trig), .sof_mode(sof_mode), .vs_pol(vs_pol),
    .hs_pol(hs_pol), .pclk_pol(pclk_pol), .swap(swap),
    .width_mode(width_mode), .cam_pclk(cam_pclk), .cam_vs(cam_vs),
    .cam_hs(cam_hs), .cam_d(cam_d), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .evt_fs(evt_fs),
    .evt_fe(evt_fe), .evt_ls(evt_ls), .evt_le(evt_le)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && n_got < 64) begin
        got[n_got] = out_data;
        n_got++;
      end
      if (evt_fs) n_fs++;
      if (evt_fe) n_fe++;
      if (evt_ls) n_ls++;
      if (evt_le) n_le++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One sensor sample: the active pixel-clock edge carries the values,
  // the return edge carries inverted data that must never be captured.
  task automatic step(input logic v, input logic h, input logic [11:0] d);
    cam_vs = v ^ vs_pol;
    cam_hs = h ^ hs_pol;
    cam_d  = d;
    clks(2);
    cam_pclk = ~cam_pclk;
    clks(2);
    cam_d = ~d;
    clks(2);
    cam_pclk = ~cam_pclk;
    clks(1);
  endtask

  task automatic one_line(input int n, input logic [11:0] base);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 12'(base + 12'(i)));
    step(1'b1, 1'b0, 12'h000);
  endtask

  task automatic frame(input int n, input logic [11:0] base);
    step(1'b0, 1'b0, 12'h000);
    step(1'b1, 1'b0, 12'h000);
    one_line(n, base);
    step(1'b0, 1'b0, 12'h000);
    clks(8);
  endtask

  // {width_mode, swap, npix, base, nwords, word0, word1}
  localparam int VW = 2 + 1 + 4 + 12 + 2 + 32 + 32;
  localparam logic [VW-1:0] VEC [0:5] = '{
    {2'b00, 1'b0, 4'd4, 12'h010, 2'd1, 32'h13121110, 32'h00000000},
    {2'b00, 1'b1, 4'd4, 12'h0A0, 2'd1, 32'hA0A1A2A3, 32'h00000000},
    {2'b00, 1'b0, 4'd6, 12'h1F0, 2'd2, 32'hF3F2F1F0, 32'h0000F5F4},
    {2'b01, 1'b0, 4'd3, 12'h5FD, 2'd2, 32'h01FE01FD, 32'h000001FF},
    {2'b10, 1'b1, 4'd3, 12'hABC, 2'd2, 32'h0ABC0ABD, 32'h0ABE0000},
    {2'b00, 1'b1, 4'd1, 12'h055, 2'd1, 32'h55000000, 32'h00000000}
  };

  initial begin
    clks(3);
    chk("R13 out_valid after reset", {31'b0, out_valid}, 32'h0);
    chk("R13 events after reset", {28'b0, evt_fs, evt_fe, evt_ls, evt_le}, 32'h0);
    rst_n = 1'b1;
    clks(2);
    en = 1'b1;

    // Table walk: R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      int g0, fs0, fe0, ls0, le0;
      logic [VW-1:0] e;
      e = VEC[v];
      width_mode = e[84:83];
      swap = e[82];
      g0 = n_got; fs0 = n_fs; fe0 = n_fe; ls0 = n_ls; le0 = n_le;
      frame(int'(e[81:78]), e[77:66]);
      chk("R9 word count", 32'(n_got - g0), 32'(e[65:64]));
      chk("R6 R7 R8 first word", got[g0], e[63:32]);
      if (e[65:64] == 2'd2) chk("R9 flushed word", got[g0 + 1], e[31:0]);
      chk("R10 frame events", 32'(n_fs - fs0 + n_fe - fe0), 32'd2);
      chk("R10 line events", 32'(n_ls - ls0 + n_le - le0), 32'd2);
    end
    width_mode = 2'b00;
    swap = 1'b0;

    // R1: both syncs active low
    begin
      int g0;
      en = 1'b0; vs_pol = 1'b1; hs_pol = 1'b1;
      cam_vs = 1'b1; cam_hs = 1'b1;
      clks(4);
      en = 1'b1;
      g0 = n_got;
      frame(4, 12'h0D0);
      chk("R1 word count", 32'(n_got - g0), 32'd1);
      chk("R1 word", got[g0], 32'hD3D2D1D0);
      en = 1'b0; vs_pol = 1'b0; hs_pol = 1'b0;
      cam_vs = 1'b0; cam_hs = 1'b0;
      clks(4);
    end

    // R2: falling-edge sampling
    begin
      int g0;
      pclk_pol = 1'b1; cam_pclk = 1'b1;
      clks(4);
      en = 1'b1;
      g0 = n_got;
      frame(4, 12'h0E0);
      chk("R2 word count", 32'(n_got - g0), 32'd1);
      chk("R2 word", got[g0], 32'hE3E2E1E0);
      en = 1'b0; pclk_pol = 1'b0; cam_pclk = 1'b0;
      clks(4);
    end

    // R3: start-of-frame arming ignores a frame already in progress
    begin
      int g0, fs0;
      sof_mode = 1'b1;
      step(1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b0, 12'h000);
      en = 1'b1;
      g0 = n_got; fs0 = n_fs;
      one_line(4, 12'h080);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R3 edge mode mid-frame words", 32'(n_got - g0), 32'd0);
      chk("R3 edge mode mid-frame fs", 32'(n_fs - fs0), 32'd0);
      step(1'b1, 1'b0, 12'h000);
      one_line(4, 12'h090);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R3 edge mode next frame fs", 32'(n_fs - fs0), 32'd1);
      chk("R3 edge mode next frame word", got[g0], 32'h93929190);
      en = 1'b0;
      sof_mode = 1'b0;
      step(1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b0, 12'h000);
      en = 1'b1;
      g0 = n_got; fs0 = n_fs;
      one_line(4, 12'h0A0);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R3 level mode mid-frame fs", 32'(n_fs - fs0), 32'd1);
      chk("R3 level mode mid-frame word", got[g0], 32'hA3A2A1A0);
    end

    // R4: deferred disable finishes the frame, then stays off
    begin
      int g0, fs0, fe0;
      frame_trig = 1'b1;
      g0 = n_got; fs0 = n_fs; fe0 = n_fe;
      step(1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b0, 12'h000);
      en = 1'b0;
      one_line(4, 12'h040);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R4 frame finished word", got[g0], 32'h43424140);
      chk("R4 frame end pulse", 32'(n_fe - fe0), 32'd1);
      frame(4, 12'h050);
      chk("R4 no later words", 32'(n_got - g0), 32'd1);
      chk("R4 no later frame start", 32'(n_fs - fs0), 32'd1);
    end

    // R5: immediate disable drops the frame and the partial word
    begin
      int g0, fe0, le0;
      frame_trig = 1'b0;
      en = 1'b1;
      g0 = n_got; fe0 = n_fe; le0 = n_le;
      step(1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b0, 12'h000);
      step(1'b1, 1'b1, 12'h060);
      step(1'b1, 1'b1, 12'h061);
      en = 1'b0;
      clks(3);
      step(1'b1, 1'b0, 12'h000);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R5 no words after abort", 32'(n_got - g0), 32'd0);
      chk("R5 no end pulses", 32'(n_fe - fe0 + n_le - le0), 32'd0);
      en = 1'b1;
      frame(4, 12'h070);
      chk("R5 partial discarded", got[g0], 32'h73727170);
    end

    // R12: core reset mid-frame while disabled
    begin
      int g0, fe0;
      frame_trig = 1'b1;
      g0 = n_got;
      step(1'b0, 1'b0, 12'h000);
      step(1'b1, 1'b0, 12'h000);
      step(1'b1, 1'b1, 12'h0B0);
      step(1'b1, 1'b1, 12'h0B1);
      en = 1'b0;
      fe0 = n_fe;
      core_rst = 1'b1;
      clks(1);
      core_rst = 1'b0;
      step(1'b1, 1'b1, 12'h0B2);
      step(1'b1, 1'b0, 12'h000);
      step(1'b0, 1'b0, 12'h000);
      clks(8);
      chk("R12 no words after core reset", 32'(n_got - g0), 32'd0);
      chk("R12 no frame end", 32'(n_fe - fe0), 32'd0);
      en = 1'b1;
      frame(4, 12'h0C0);
      chk("R12 packer cleared", got[g0], 32'hC3C2C1C0);
    end

    // R11: stalled sink keeps the first word and drops the second
    begin
      int g0;
      g0 = n_got;
      out_ready = 1'b0;
      frame(8, 12'h020);
      chk("R11 held valid", {31'b0, out_valid}, 32'h1);
      chk("R11 held data", out_data, 32'h23222120);
      out_ready = 1'b1;
      clks(4);
      chk("R11 one word delivered", 32'(n_got - g0), 32'd1);
      chk("R11 delivered word", got[g0], 32'h23222120);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule